// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This block takes a decoded relative-jump instruction and decides, in one registered step, whether control flow leaves the sequential path. It receives a three-bit condition code, a signed ten-bit word displacement, the address of the jump instruction and the four arithmetic flags (carry, zero, negative, overflow). When the request strobe is high, it registers three results on the following clock edge: a valid strobe, a taken flag and the address of the next instruction.

The next address is the jump address plus two when the jump falls through. When the jump is taken, it is the jump address plus two plus twice the sign-extended displacement. Both cases wrap modulo 2^16, and bit 0 of the result is always zero. Two of the eight codes form signed comparisons from the negative and overflow flags. Code 7 ignores every flag.

Top module: `jcond_resolver`

## Requirements
- R1: While rst_n is low, and on the first edge after it rises with no request, res_valid, res_taken and res_pc are all zero.
- R2: One clock edge after a cycle with req_valid high, res_valid is 1. After a cycle with req_valid low, res_valid is 0 and res_taken and res_pc keep their previous values.
- R3: Condition code 0 is taken when flag_z is 0. Code 1 is taken when flag_z is 1.
- R4: Condition code 2 is taken when flag_c is 0. Code 3 is taken when flag_c is 1.
- R5: Condition code 4 is taken when flag_n is 1. The other flags have no effect on it.
- R6: Condition code 5 is taken when flag_n equals flag_v. Code 6 is taken when they differ.
- R7: Condition code 7 is always taken, for every combination of the four flags.
- R8: A taken jump gives res_pc = (req_pc + 2 + 2*sext(req_off)) mod 2^16, where req_off is a signed 10-bit word count. This holds at the extremes -512 and +511 and across wrap-around at both ends of the address space.
- R9: A jump that is not taken gives res_pc = (req_pc + 2) mod 2^16.
- R10: Bit 0 of res_pc is always 0, including when req_pc is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe: evaluate the inputs this cycle |
| req_cond | input | 3 | Condition code |
| req_off | input | 10 | Signed word displacement |
| req_pc | input | 16 | Address of the jump instruction |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| res_valid | output | 1 | Result strobe, one cycle after req_valid |
| res_taken | output | 1 | Registered taken decision |
| res_pc | output | 16 | Registered next-instruction address |

## Verification
A wrong decision appears on res_taken on the edge after the request. It also moves res_pc by exactly 2*sext(offset) from the fall-through address, so the bench compares both outputs one cycle after each strobe. An arithmetic fault in the target adder, such as a lost carry, a wrong sign extension or a missing scale, shows only in res_pc and only for taken jumps. The vector table therefore places offsets at both extremes and PCs near both ends of memory. A fault in the hold path shows on the first idle cycle, when the registered outputs must stay unchanged.

// File: rtl/jcond_pkg.sv
package jcond_pkg;
  localparam int unsigned PC_W   = 16;
  localparam int unsigned OFF_W  = 10;
  localparam int unsigned COND_W = 3;

  typedef enum logic [COND_W-1:0] {
    JC_ZCLR  = 3'd0,
    JC_ZSET  = 3'd1,
    JC_CCLR  = 3'd2,
    JC_CSET  = 3'd3,
    JC_NSET  = 3'd4,
    JC_SGE   = 3'd5,
    JC_SLT   = 3'd6,
    JC_ALWAYS= 3'd7
  } jcond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } jflags_t;

  function automatic logic cond_met(input jcond_e cc, input jflags_t f);
    case (cc)
      JC_ZCLR:  return !f.z;
      JC_ZSET:  return f.z;
      JC_CCLR:  return !f.c;
      JC_CSET:  return f.c;
      JC_NSET:  return f.n;
      JC_SGE:   return f.n == f.v;
      JC_SLT:   return f.n != f.v;
      default:  return 1'b1;
    endcase
  endfunction

  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
    return {pc[PC_W-1:1], 1'b0} + PC_W'(2);
  endfunction

  function automatic logic [PC_W-1:0] rel_pc(input logic [PC_W-1:0] pc,
                                             input logic [OFF_W-1:0] off);
    logic [PC_W-1:0] disp;
    disp = {{(PC_W-OFF_W-1){off[OFF_W-1]}}, off, 1'b0};
    return seq_pc(pc) + disp;
  endfunction
endpackage

// File: rtl/jcond_eval.sv
module jcond_eval
  import jcond_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  jflags_t           flags,
  output logic              taken
);
  always_comb taken = cond_met(jcond_e'(cond), flags);
endmodule

// File: rtl/jcond_target.sv
module jcond_target
  import jcond_pkg::*;
(
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic             take,
  output logic [PC_W-1:0]  fall_pc,
  output logic [PC_W-1:0] jump_pc,
  output logic [PC_W-1:0]  next_pc
);
  always_comb begin
    fall_pc = seq_pc(pc);
    jump_pc = rel_pc(pc, off);
    next_pc = take ? jump_pc : fall_pc;
  end
endmodule

// File: rtl/jcond_resolver.sv
module jcond_resolver
  import jcond_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_cond,
  input  logic [9:0]  req_off,
  input  logic [15:0] req_pc,
  input  logic        flag_c,
  input  logic        flag_z,
  input  logic        flag_n,
  input  logic        flag_v,
  output logic        res_valid,
  output logic        res_taken,
  output logic [15:0] res_pc
);
  jflags_t         flags_w;
  logic            take_w;
  logic [PC_W-1:0] fall_w, jump_w, next_w;

  assign flags_w = '{c: flag_c, z: flag_z, n: flag_n, v: flag_v};

  jcond_eval u_eval (
    .cond  (req_cond),
    .flags (flags_w),
    .taken (take_w)
  );

  jcond_target u_tgt (
    .pc      (req_pc),
    .off     (req_off),
    .take    (take_w),
    .fall_pc (fall_w),
    .jump_pc (jump_w),
    .next_pc (next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_taken <= 1'b0;
      res_pc    <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_taken <= take_w;
        res_pc    <= next_w;
      end
    end
  end
endmodule

// File: rtl/jcond_resolver_chk.sv
module jcond_resolver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_cond,
  input logic [15:0] req_pc,
  input logic        flag_c,
  input logic        flag_z,
  input logic        flag_n,
  input logic        flag_v,
  input logic        take_w,
  input logic [15:0] fall_w,
  input logic        res_valid,
  input logic        res_taken,
  input logic [15:0] res_pc
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid) else $error("valid"); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && $stable(res_pc) && $stable(res_taken))) else $error("hold"); // R2
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    res_pc[0] == 1'b0) else $error("even"); // R10
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cond == 3'd7) |=> res_taken) else $error("always"); // R7
  AST_SIGNED_GE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cond == 3'd5) |=> (res_taken == ($past(flag_n) == $past(flag_v)))) else $error("ge"); // R6
  AST_ZERO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cond == 3'd1) |=> (res_taken == $past(flag_z))) else $error("z"); // R3
  AST_CARRY_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cond == 3'd3) |=> (res_taken == $past(flag_c))) else $error("c"); // R4
  AST_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !take_w) |=> (res_pc == $past(fall_w))) else $error("fall"); // R9
  AST_FALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !take_w && !req_pc[0]) |-> (fall_w == req_pc + 16'd2)) else $error("step"); // R9
  AST_NEG_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cond == 3'd4) |-> (take_w == flag_n)) else $error("n"); // R5
endmodule

bind jcond_resolver jcond_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cond(req_cond),
  .req_pc(req_pc), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n),
  .flag_v(flag_v), .take_w(take_w), .fall_w(fall_w),
  .res_valid(res_valid), .res_taken(res_taken), .res_pc(res_pc)
);

// File: tb/jcond_resolver_tb.sv
module jcond_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_cond = '0;
  logic [9:0]  req_off = '0;
  logic [15:0] req_pc = '0;
  logic        flag_c = 0, flag_z = 0, flag_n = 0, flag_v = 0;
  logic        res_valid, res_taken;
  logic [15:0] res_pc;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  jcond_resolver dut_i (.*);

  // vector: cond, off, pc, flags {c,z,n,v}, expected taken
  typedef struct packed {
    logic [2:0]  cond;
    logic [9:0]  off;
    logic [15:0] pc;
    logic [3:0]  cznv;
    logic        tk;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{3'd0, 10'd4,    16'h1000, 4'b0000, 1'b1}, // R3
    '{3'd0, 10'd4,    16'h1000, 4'b0100, 1'b0}, // R3
    '{3'd1, 10'd4,    16'h1000, 4'b0100, 1'b1}, // R3
    '{3'd1, 10'd4,    16'h1000, 4'b1011, 1'b0}, // R3
    '{3'd2, 10'h3FF,  16'h2000, 4'b0000, 1'b1}, // R4
    '{3'd2, 10'h3FF,  16'h2000, 4'b1000, 1'b0}, // R4
    '{3'd3, 10'd7,    16'h2000, 4'b1000, 1'b1}, // R4
    '{3'd3, 10'd7,    16'h2000, 4'b0111, 1'b0}, // R4
    '{3'd4, 10'd1,    16'h3000, 4'b0010, 1'b1}, // R5
    '{3'd4, 10'd1,    16'h3000, 4'b1101, 1'b0}, // R5
    '{3'd5, 10'd2,    16'h4000, 4'b0000, 1'b1}, // R6
    '{3'd5, 10'd2,    16'h4000, 4'b0011, 1'b1}, // R6
    '{3'd5, 10'd2,    16'h4000, 4'b0010, 1'b0}, // R6
    '{3'd6, 10'd2,    16'h4000, 4'b0001, 1'b1}, // R6
    '{3'd6, 10'd2,    16'h4000, 4'b0011, 1'b0}, // R6
    '{3'd7, 10'h200,  16'h0100, 4'b0000, 1'b1}, // R7 R8 min offset, wraps low
    '{3'd7, 10'h1FF,  16'hFF00, 4'b1111, 1'b1}, // R7 R8 max offset, wraps high
    '{3'd7, 10'd0,    16'hFFFE, 4'b0101, 1'b1}, // R8 wrap to 0
    '{3'd1, 10'd9,    16'hFFFE, 4'b0000, 1'b0}, // R9 wrap to 0
    '{3'd7, 10'd3,    16'h1235, 4'b1010, 1'b1}  // R10 odd pc
  };

  function automatic logic [15:0] model_pc(input logic [15:0] pc, input logic [9:0] off, input logic tk);
    int signed s;
    int unsigned a;
    s = $signed(off);
    a = (pc & 16'hFFFE) + 2 + (tk ? 2 * s : 0);
    return a[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_cond = v.cond; req_off = v.off; req_pc = v.pc;
    {flag_c, flag_z, flag_n, flag_v} = v.cznv;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    #1;
    check("R1 reset valid", res_valid, 0);
    check("R1 reset pc", res_pc, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset valid", res_valid, 0);
    check("R1 post-reset taken", res_taken, 0);
    check("R1 post-reset pc", res_pc, 0);

    for (int i = 0; i < NV; i++) begin
      issue(VT[i]);
      check("R2 valid", res_valid, 1);
      check($sformatf("R3-7 taken vec %0d", i), res_taken, VT[i].tk);
      check($sformatf("R8 R9 pc vec %0d", i), res_pc, model_pc(VT[i].pc, VT[i].off, VT[i].tk));
      check("R10 even", res_pc[0], 0);
    end

    // R7: every flag combination
    for (int f = 0; f < 16; f++) begin
      issue('{3'd7, 10'd5, 16'h0800, f[3:0], 1'b1});
      check("R7 always taken", res_taken, 1);
    end

    // R2 hold while idle, changing inputs
    held = res_pc;
    @(negedge clk);
    req_cond = 3'd0; req_pc = 16'h5555; flag_z = 1;
    @(negedge clk);
    check("R2 idle valid", res_valid, 0);
    check("R2 idle pc hold", res_pc, held);
    check("R2 idle taken hold", res_taken, 1);

    // back-to-back requests
    @(negedge clk);
    req_valid = 1; req_cond = 3'd0; req_pc = 16'h0010; req_off = 10'd1; flag_z = 0;
    @(negedge clk);
    check("R3 b2b first", res_pc, 16'h0014);
    req_cond = 3'd1;
    @(negedge clk);
    req_valid = 0;
    check("R9 b2b second", res_pc, 16'h0012);
    check("R2 b2b valid", res_valid, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule